// File: doc/BRIEF.md
# Virtual Supervisor Interrupt Pending Aggregator

This block produces the four virtual-supervisor interrupt pending bits of a hart that supports a hypervisor. It owns five small registers: a guest-external enable vector, a time offset, a virtual timer compare value, a 6-bit guest selector, and the bits the hypervisor injects by hand. It combines these registers with the live per-guest external pending vector, a platform external interrupt line and the free-running time counter. From them it derives the external, timer, guest-external summary and software pending outputs.

Software reaches the registers through a plain write port (enable, select, data) and a combinational read port (select in, data out). The software pending bit has its own narrow path. It is fed by three alias write ports, one for each privilege view (machine, hypervisor, guest supervisor), and the caller keeps them one-hot. Address decoding, delegation and arbitration live elsewhere. Every pin is a level-type control or status signal, so no valid/ready handshake applies.

Top module: `vsint_pending`

## Requirements
- R1: `vseip` is high when the injected external bit is set, or the platform line `plat_vseip` is high, or the guest-pending bit picked by the selector is set.
- R2: A selector value of zero picks nothing, so the guest pick adds nothing to `vseip`.
- R3: `vstip` is the injected timer bit OR'd with a registered compare flag. The flag takes, one clock after the fact, the value of `(time_now + offset) mod 2^64 >= compare`, and the compare is unsigned.
- R4: `sgeip` is the OR-reduction of the bitwise AND of `gext_pend` and the enable vector.
- R5: Index 0 of the enable vector reads as zero and ignores writes. The pending vector only carries indices 1..GEILEN, and index 0 counts as zero.
- R6: A selector write stores `csr_wdata[5:0]` only when that value is at most GEILEN. Otherwise the old value stays. The selector reads back zero-extended.
- R7: `vssip` takes `alias_wbit[i]` from whichever single `alias_we[i]` is high. It holds when none is high. Index 0 is the machine view, 1 the hypervisor view and 2 the guest view.
- R8: After reset, the injected bits, enable vector, selector and offset are zero, the compare value is all ones, and all four outputs are low.
- R9: The select codes are 0 enable, 1 offset, 2 compare, 3 selector and 4 injected. The injected register holds bit 0 soft, bit 1 timer and bit 2 external. A write to it changes bits 1 and 2 only, and codes 5 to 7 write nothing and read zero.
- R10: Written registers show their new value on `csr_rdata` and the outputs right after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 3 | Register select for writes |
| csr_wdata | input | 64 | Write data |
| csr_rsel | input | 3 | Register select for reads |
| csr_rdata | output | 64 | Read data, combinational |
| alias_we | input | 3 | One-hot soft-pending alias write strobes |
| alias_wbit | input | 3 | Soft-pending alias write values |
| gext_pend | input | GEILEN (bits GEILEN:1) | Per-guest external pending vector |
| plat_vseip | input | 1 | Platform guest external interrupt line |
| time_now | input | 64 | Free-running time counter |
| vseip | output | 1 | Guest external pending |
| vstip | output | 1 | Guest timer pending |
| sgeip | output | 1 | Guest-external summary pending |
| vssip | output | 1 | Guest software pending |

## Verification
The bench builds the block with GEILEN set to 13. That makes selector values 14 through 63 illegal, and random sweeps hit them often alongside the legal ones. With 13 guest bits, random enable and pending vectors produce both empty and non-empty intersections. The highest index, 13, is reachable from the selector. A separate run of offsets near 2^64 drives the timer sum through wrap-around while the time counter steps across the compare threshold.

// File: rtl/vsint_pkg.sv
package vsint_pkg;
  localparam int XLEN    = 64;
  localparam int SEL_W   = 3;
  localparam int VGEIN_W = 6;
  localparam int NALIAS  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_GEIE   = 3'd0,
    SEL_TDELTA = 3'd1,
    SEL_TCMP   = 3'd2,
    SEL_VGEIN  = 3'd3,
    SEL_INJ    = 3'd4
  } vs_sel_e;

  localparam int INJ_SSIP = 0;
  localparam int INJ_STIP = 1;
  localparam int INJ_SEIP = 2;
endpackage

// File: rtl/vsint_gext.sv
module vsint_gext
  import vsint_pkg::*;
#(
  parameter int GEILEN = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_geie,
  input  logic [GEILEN-1:0]  geie_wd,
  input  logic               wr_vgein,
  input  logic [VGEIN_W-1:0] vgein_wd,
  input  logic [GEILEN:1]    gext_pend,
  output logic [GEILEN:0]    geie,
  output logic [VGEIN_W-1:0] vgein,
  output logic               pick,
  output logic               sgeip
);
  localparam int PICK_W = 1 << VGEIN_W;

  logic [GEILEN:1]    geie_q;
  logic [VGEIN_W-1:0] vgein_q;
  logic [GEILEN:0]    pend_full;
  logic [PICK_W-1:0]  pend_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      geie_q  <= '0;
      vgein_q <= '0;
    end else begin
      if (wr_geie) geie_q <= geie_wd;
      if (wr_vgein && (vgein_wd <= VGEIN_W'(GEILEN))) vgein_q <= vgein_wd;
    end
  end

  assign pend_full = {gext_pend, 1'b0};
  assign pend_ext  = PICK_W'(pend_full);
  assign geie      = {geie_q, 1'b0};
  assign vgein     = vgein_q;
  assign pick      = pend_ext[vgein_q];
  assign sgeip     = |(pend_full & geie);
endmodule

// File: rtl/vsint_vtimer.sv
module vsint_vtimer
  import vsint_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_delta,
  input  logic            wr_cmp,
  input  logic [XLEN-1:0] wd,
  input  logic [XLEN-1:0] time_now,
  output logic [XLEN-1:0] delta,
  output logic [XLEN-1:0] cmp,
  output logic            fire
);
  logic [XLEN-1:0] delta_q, cmp_q, vtime;
  logic            fire_q;

  assign vtime = time_now + delta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta_q <= '0;
      cmp_q   <= '1;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= (vtime >= cmp_q);
      if (wr_delta) delta_q <= wd;
      if (wr_cmp)   cmp_q   <= wd;
    end
  end

  assign delta = delta_q;
  assign cmp   = cmp_q;
  assign fire  = fire_q;
endmodule

// File: rtl/vsint_inject.sv
module vsint_inject
  import vsint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_inj,
  input  logic              stip_wd,
  input  logic              seip_wd,
  input  logic [NALIAS-1:0] alias_we,
  input  logic [NALIAS-1:0] alias_wbit,
  output logic              ssip,
  output logic              stip,
  output logic              seip
);
  logic [NALIAS-1:0] hit;
  logic ssip_q, stip_q, seip_q;

  for (genvar g = 0; g < NALIAS; g++) begin : g_alias
    assign hit[g] = alias_we[g] & alias_wbit[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssip_q <= 1'b0;
      stip_q <= 1'b0;
      seip_q <= 1'b0;
    end else begin
      if (|alias_we) ssip_q <= |hit;
      if (wr_inj) begin
        stip_q <= stip_wd;
        seip_q <= seip_wd;
      end
    end
  end

  assign ssip = ssip_q;
  assign stip = stip_q;
  assign seip = seip_q;
endmodule

// File: rtl/vsint_pending.sv
module vsint_pending
  import vsint_pkg::*;
#(
  parameter int GEILEN = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_we,
  input  logic [SEL_W-1:0]     csr_sel,
  input  logic [XLEN-1:0]      csr_wdata,
  input  logic [SEL_W-1:0]     csr_rsel,
  output logic [XLEN-1:0]      csr_rdata,
  input  logic [NALIAS-1:0]    alias_we,
  input  logic [NALIAS-1:0]    alias_wbit,
  input  logic [GEILEN:1]      gext_pend,
  input  logic                 plat_vseip,
  input  logic [XLEN-1:0]      time_now,
  output logic                 vseip,
  output logic                 vstip,
  output logic                 sgeip,
  output logic                 vssip
);
  logic [GEILEN:0]    geie;
  logic [VGEIN_W-1:0] vgein_q;
  logic [XLEN-1:0]    delta_q, tcmp_q;
  logic               gext_pick, tfire;
  logic               inj_ssip, inj_stip, inj_seip;
  logic               wr_geie, wr_delta, wr_cmp, wr_vgein, wr_inj;

  assign wr_geie  = csr_we && (csr_sel == SEL_GEIE);
  assign wr_delta = csr_we && (csr_sel == SEL_TDELTA);
  assign wr_cmp   = csr_we && (csr_sel == SEL_TCMP);
  assign wr_vgein = csr_we && (csr_sel == SEL_VGEIN);
  assign wr_inj   = csr_we && (csr_sel == SEL_INJ);

  vsint_gext #(.GEILEN(GEILEN)) u_gext (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_geie  (wr_geie),
    .geie_wd  (csr_wdata[GEILEN:1]),
    .wr_vgein (wr_vgein),
    .vgein_wd (csr_wdata[VGEIN_W-1:0]),
    .gext_pend(gext_pend),
    .geie     (geie),
    .vgein    (vgein_q),
    .pick     (gext_pick),
    .sgeip    (sgeip)
  );

  vsint_vtimer u_vtimer (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_delta(wr_delta),
    .wr_cmp  (wr_cmp),
    .wd      (csr_wdata),
    .time_now(time_now),
    .delta   (delta_q),
    .cmp     (tcmp_q),
    .fire    (tfire)
  );

  vsint_inject u_inject (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_inj    (wr_inj),
    .stip_wd   (csr_wdata[INJ_STIP]),
    .seip_wd   (csr_wdata[INJ_SEIP]),
    .alias_we  (alias_we),
    .alias_wbit(alias_wbit),
    .ssip      (inj_ssip),
    .stip      (inj_stip),
    .seip      (inj_seip)
  );

  always_comb begin
    unique case (csr_rsel)
      SEL_GEIE:   csr_rdata = XLEN'(geie);
      SEL_TDELTA: csr_rdata = delta_q;
      SEL_TCMP:   csr_rdata = tcmp_q;
      SEL_VGEIN:  csr_rdata = XLEN'(vgein_q);
      SEL_INJ:    csr_rdata = XLEN'({inj_seip, inj_stip, inj_ssip});
      default:    csr_rdata = '0;
    endcase
  end

  assign vseip = inj_seip | gext_pick | plat_vseip;
  assign vstip = inj_stip | tfire;
  assign vssip = inj_ssip;
endmodule

// File: rtl/vsint_pending_chk.sv
module vsint_pending_chk #(
  parameter int GEILEN = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [63:0]       time_now,
  input logic [63:0]       delta_q,
  input logic [63:0]       tcmp_q,
  input logic              vstip,
  input logic [2:0]        alias_we,
  input logic              vssip,
  input logic [5:0]        vgein_q,
  input logic              plat_vseip,
  input logic              inj_seip,
  input logic              vseip,
  input logic [GEILEN:1]   gext_pend,
  input logic [GEILEN:0]   geie,
  input logic              sgeip
);
  AST_VSTIP_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((time_now + delta_q) >= tcmp_q) |=> vstip); // R3

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    vgein_q <= 6'(GEILEN)); // R6

  AST_GEIE_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    !geie[0]); // R5

  AST_SSIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_we == 3'b000) |=> $stable(vssip)); // R7

  AST_SSIP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alias_we)); // R7

  AST_SEIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (vgein_q == 6'd0 && !plat_vseip && !inj_seip) |-> !vseip); // R2

  AST_SGEIP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((gext_pend & geie[GEILEN:1]) == '0) |-> !sgeip); // R4
endmodule

bind vsint_pending vsint_pending_chk #(.GEILEN(GEILEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .time_now  (time_now),
  .delta_q   (delta_q),
  .tcmp_q    (tcmp_q),
  .vstip     (vstip),
  .alias_we  (alias_we),
  .vssip     (vssip),
  .vgein_q   (vgein_q),
  .plat_vseip(plat_vseip),
  .inj_seip  (inj_seip),
  .vseip     (vseip),
  .gext_pend (gext_pend),
  .geie      (geie),
  .sgeip     (sgeip)
);

// File: tb/vsint_pending_test.sv
module vsint_pending_test;
  localparam int GEILEN = 13;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              csr_we = 1'b0;
  logic [2:0]        csr_sel = '0;
  logic [63:0]       csr_wdata = '0;
  logic [2:0]        csr_rsel = '0;
  logic [63:0]       csr_rdata;
  logic [2:0]        alias_we = '0;
  logic [2:0]        alias_wbit = '0;
  logic [GEILEN:1]   gext_pend = '0;
  logic              plat_vseip = 1'b0;
  logic [63:0]       time_now = '0;
  logic              vseip, vstip, sgeip, vssip;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsint_pending #(.GEILEN(GEILEN)) uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rsel(csr_rsel), .csr_rdata(csr_rdata),
    .alias_we(alias_we), .alias_wbit(alias_wbit), .gext_pend(gext_pend),
    .plat_vseip(plat_vseip), .time_now(time_now), .vseip(vseip),
    .vstip(vstip), .sgeip(sgeip), .vssip(vssip)
  );

  typedef struct {
    bit          seip, stip, sgei, ssip;
    logic [63:0] rd;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_tests = 0;
  int          n_fail = 0;

  // bench model of architectural state
  logic [GEILEN:1] m_geie = '0;
  logic [5:0]      m_vgein = '0;
  logic [63:0]     m_delta = '0;
  logic [63:0]     m_tcmp = '1;
  bit              m_ssip = 0, m_stip = 0, m_seip = 0;

  // next-step stimulus for persistent inputs
  logic [GEILEN:1] n_pend = '0;
  bit              n_plat = 0;
  logic [63:0]     n_time = '0;
  logic [2:0]      n_rsel = '0;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(bit we, logic [2:0] sel, logic [63:0] wd,
                      logic [2:0] aw, logic [2:0] ab, string tag);
    exp_t e;
    bit   fire;
    logic [63:0] vt;
    @(negedge clk);
    csr_we = we; csr_sel = sel; csr_wdata = wd;
    alias_we = aw; alias_wbit = ab;
    gext_pend = n_pend; plat_vseip = n_plat; time_now = n_time; csr_rsel = n_rsel;
    vt = n_time + m_delta;
    fire = (vt >= m_tcmp);
    if (we) begin
      case (sel)
        3'd0: m_geie = wd[GEILEN:1];
        3'd1: m_delta = wd;
        3'd2: m_tcmp = wd;
        3'd3: if (wd[5:0] <= 6'(GEILEN)) m_vgein = wd[5:0];
        3'd4: begin m_stip = wd[1]; m_seip = wd[2]; end
        default: ;
      endcase
    end
    if (aw != 3'b000) m_ssip = |(aw & ab);
    e.seip = m_seip | n_plat | ((m_vgein != 0) ? n_pend[m_vgein] : 1'b0);
    e.stip = m_stip | fire;
    e.sgei = |(n_pend & m_geie);
    e.ssip = m_ssip;
    case (n_rsel)
      3'd0: e.rd = 64'({m_geie, 1'b0});
      3'd1: e.rd = m_delta;
      3'd2: e.rd = m_tcmp;
      3'd3: e.rd = 64'(m_vgein);
      3'd4: e.rd = 64'({m_seip, m_stip, m_ssip});
      default: e.rd = '0;
    endcase
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: results of a step are visible just after the following posedge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "vseip", 64'(vseip), 64'(e.seip));
      chk(e.tag, "vstip", 64'(vstip), 64'(e.stip));
      chk(e.tag, "sgeip", 64'(sgeip), 64'(e.sgei));
      chk(e.tag, "vssip", 64'(vssip), 64'(e.ssip));
      chk(e.tag, "rdata", csr_rdata, e.rd);
    end
  end

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values at the ports
    chk("R8", "vseip", 64'(vseip), 0);
    chk("R8", "vstip", 64'(vstip), 0);
    chk("R8", "sgeip", 64'(sgeip), 0);
    chk("R8", "vssip", 64'(vssip), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) begin
      n_rsel = 3'(s);
      step(0, 0, 0, 0, 0, "R8_R9 reset readback");
    end

    // R5: enable bit 0 ignores writes
    n_rsel = 3'd0;
    step(1, 3'd0, '1, 0, 0, "R5 enable write all ones");
    step(0, 0, 0, 0, 0, "R5 enable bit0 reads zero");
    // R9: unused select codes write nothing
    n_rsel = 3'd2;
    step(1, 3'd6, 64'h5, 0, 0, "R9 unused select");
    step(1, 3'd7, 64'h0, 0, 0, "R9 unused select 7");

    // R9/R1: injected register; bit 0 not writable by csr
    n_rsel = 3'd4;
    step(1, 3'd4, 64'h7, 0, 0, "R9 inject write 111");
    step(1, 3'd4, 64'h0, 0, 0, "R1 inject clear");
    n_plat = 1;
    step(0, 0, 0, 0, 0, "R1 platform line");
    n_plat = 0;

    // R7: alias ports, each view, and hold
    step(0, 0, 0, 3'b001, 3'b001, "R7 machine view set");
    step(0, 0, 0, 3'b010, 3'b000, "R7 hypervisor view clear");
    step(0, 0, 0, 3'b100, 3'b100, "R7 guest view set");
    step(0, 0, 0, 3'b000, 3'b111, "R7 hold");
    step(0, 0, 0, 3'b010, 3'b101, "R7 hypervisor clear ignores others");

    // R2: selector zero contributes nothing
    n_rsel = 3'd3;
    step(1, 3'd3, 64'd0, 0, 0, "R2 selector zero");
    n_pend = '1;
    step(0, 0, 0, 0, 0, "R2 all pending selector zero");
    // R6 boundary values
    step(1, 3'd3, 64'(GEILEN), 0, 0, "R6 selector max legal");
    step(1, 3'd3, 64'(GEILEN + 1), 0, 0, "R6 selector just illegal");
    step(1, 3'd3, 64'h7F, 0, 0, "R6 upper bits ignored value 63");
    n_pend = '0;
    step(0, 0, 0, 0, 0, "R1 selected guest idle");

    // R1/R4/R6: random sweep
    for (int i = 0; i < 60; i++) begin
      n_rsel = 3'($urandom_range(0, 4));
      n_pend = GEILEN'($urandom);
      n_plat = ($urandom_range(0, 7) == 0);
      if (i % 3 == 0) step(1, 3'd3, 64'($urandom_range(0, 63)), 0, 0, "R6 random selector");
      else if (i % 3 == 1) step(1, 3'd0, {$urandom, $urandom}, 0, 0, "R4 random enable");
      else step(0, 0, 0, 0, 0, "R1 random pending");
    end
    n_plat = 0;
    n_pend = '0;

    // R3: threshold straddle
    n_rsel = 3'd1;
    step(1, 3'd1, 64'd1000, 0, 0, "R10 offset write");
    n_rsel = 3'd2;
    step(1, 3'd2, 64'd5000, 0, 0, "R10 compare write");
    for (int t = 3997; t <= 4002; t++) begin
      n_time = 64'(t);
      step(0, 0, 0, 0, 0, "R3 straddle");
    end
    // R10: wrapping sum
    step(1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFB, 0, 0, "R10 wrap offset");
    step(1, 3'd2, 64'd5, 0, 0, "R10 wrap compare");
    for (int t = 8; t <= 12; t++) begin
      n_time = 64'(t);
      step(0, 0, 0, 0, 0, "R10 wrap straddle");
    end
    n_time = 64'd10;
    step(1, 3'd2, 64'd6, 0, 0, "R3 compare raised");
    step(0, 0, 0, 0, 0, "R3 after raise");
    step(1, 3'd4, 64'h2, 0, 0, "R3 injected timer");
    step(0, 0, 0, 0, 0, "R3 injected held");
    // random time sweep
    for (int i = 0; i < 30; i++) begin
      n_time = 64'(($urandom_range(0, 20)));
      step(0, 0, 0, 0, 0, "R3 random time");
    end

    @(negedge clk);
    csr_we = 0; alias_we = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule